// File: doc/BRIEF.md
# PCI Clock Stop Gate

This block gates a bank of PCI-rate output clocks. Each output in the bank takes either the base clock `clk_i` (33 MHz rate) or the double-rate clock `clk2x_i` (66 MHz rate). The two clocks rise together. A dedicated free-running output comes from the base clock.

An active-low stop request passes through a two-flop synchronizer on the base clock. Gate enables are registered on the falling edge of the clock they gate. An output therefore only stops or restarts while its clock is low, and every visible high phase has full width.

Per-output enable bits, free-run override bits and a rate-select bit decide which outputs the stop request affects. A strap input is captured once after reset. It decides whether the stop function is active. The strap also decides whether one designated shared output is held low, because its pin then serves as the stop input.

Top module: `pci_clk_stop`

## Requirements
- R1: While `rst_ni` is low, and until the first base-clock falling edge after reset is released, every output is low.
- R2: The block samples `stop_ni` on rising edges of `clk_i` through two flops. Consider a low level captured at rising edge m−1. At the falling edge that follows rising edge m, every affected output parks low. An output is affected when its rate bit is 0 (33 MHz rate), its free-run bit is 0 and the captured strap is 1. It stays low while the request persists.
- R3: Every high phase on a 33 MHz rate output lasts exactly one full high phase of `clk_i`, with no shortened pulse at stop, restart or enable change.
- R4: After `stop_ni` returns high, affected outputs resume with the same two-edge latency as in R2, starting with a full high phase on a rising edge of `clk_i`.
- R5: `pci_free_o` follows `clk_i` whenever `en_free_i` is 1, regardless of `stop_ni`. The enable is applied at `clk_i` falling edges.
- R6: An output with `mode66_i[k]` = 1 outputs `clk2x_i`, gated only by `en_i[k]`. That enable is registered on `clk2x_i` falling edges, and `stop_ni` has no effect on the output.
- R7: A 33 MHz rate output with `free_i[k]` = 1 keeps running while the stop request is active.
- R8: `en_i[k]` = 0 forces output k low from the next `clk_i` falling edge (or `clk2x_i` falling edge in 66 MHz mode), independent of the stop state.
- R9: The block captures `strap_stop_i` at the first `clk_i` rising edge after reset. If the strap is 0, `stop_ni` is ignored and output `SHARED_IDX` is an ordinary clock output. If the strap is 1, output `SHARED_IDX` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base PCI-rate clock |
| clk2x_i | input | 1 | Double-rate clock, rising edges aligned with clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_stop_i | input | 1 | Strap enabling the stop function, captured once after reset |
| stop_ni | input | 1 | Active-low stop request |
| en_i | input | N_OUT | Per-output enable |
| free_i | input | N_OUT | Per-output free-run override |
| mode66_i | input | N_OUT | Per-output rate select (1 = clk2x_i source), static during operation |
| en_free_i | input | 1 | Enable of the free-running output |
| pci_o | output | N_OUT | Gated output clocks |
| pci_free_o | output | 1 | Free-running output clock |

## Verification
Stop and release take effect at the falling edge that follows the second rising edge after the change, so the first changed high phase comes one clock later. An enable change on a base-rate output shows in the high phase after the next falling edge of `clk_i`. On a double-rate output it shows after the next falling edge of `clk2x_i`. The bench model applies each of these delays in its own event-driven state and compares every output 1.2 ns after each `clk2x_i` edge. The bench drives inputs 0.5 ns after a falling edge of `clk_i`, so no sample coincides with an input change. One output's high-phase width is also timed edge to edge to catch runt pulses.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned PCS_SYNC_STAGES = 2;
  typedef enum logic {SRC_BASE = 1'b0, SRC_FAST = 1'b1} pcs_src_e;
endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int unsigned STAGES = pcs_pkg::PCS_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/pcs_strap.sv
module pcs_strap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic strap_o
);
  logic done_q, strap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      strap_q <= 1'b0;
    end else if (!done_q) begin
      done_q  <= 1'b1;
      strap_q <= strap_i;
    end
  end

  assign strap_o = strap_q;
endmodule

// File: rtl/pcs_gate_cell.sv
module pcs_gate_cell (
  input  logic clk_i,
  input  logic clk2x_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hold_i,
  input  logic stop_i,
  input  logic force_off_i,
  input  logic mode66_i,
  output logic clk_o
);
  import pcs_pkg::*;

  logic run33_q, run66_q;
  pcs_src_e src;

  // enables move only while the gated clock is low
  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) run33_q <= 1'b0;
    else         run33_q <= en_i & ~force_off_i & (hold_i | ~stop_i);

  always_ff @(negedge clk2x_i or negedge rst_ni)
    if (!rst_ni) run66_q <= 1'b0;
    else         run66_q <= en_i & ~force_off_i;

  assign src   = mode66_i ? SRC_FAST : SRC_BASE;
  assign clk_o = (src == SRC_FAST) ? (clk2x_i & run66_q) : (clk_i & run33_q);

  p_fast_follows_en_r6: assert property (@(negedge clk2x_i) disable iff (!rst_ni)
    (mode66_i && en_i && !force_off_i) |=> clk_o);
endmodule

// File: rtl/pci_clk_stop.sv
module pci_clk_stop #(
  parameter int unsigned N_OUT      = 6,
  parameter int unsigned SHARED_IDX = 5
) (
  input  logic             clk_i,
  input  logic             clk2x_i,
  input  logic             rst_ni,
  input  logic             strap_stop_i,
  input  logic             stop_ni,
  input  logic [N_OUT-1:0] en_i,
  input  logic [N_OUT-1:0] free_i,
  input  logic [N_OUT-1:0] mode66_i,
  input  logic             en_free_i,
  output logic [N_OUT-1:0] pci_o,
  output logic             pci_free_o
);
  logic stop_n_sync, strap_q, stop_act;

  pcs_sync #(.STAGES(pcs_pkg::PCS_SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stop_ni), .q_o(stop_n_sync)
  );

  pcs_strap u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_i(strap_stop_i), .strap_o(strap_q)
  );

  assign stop_act = strap_q & ~stop_n_sync;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam bit IS_SHARED = (k == SHARED_IDX);
    logic force_off;
    assign force_off = IS_SHARED & strap_q;

    pcs_gate_cell u_cell (
      .clk_i(clk_i), .clk2x_i(clk2x_i), .rst_ni(rst_ni),
      .en_i(en_i[k]), .hold_i(free_i[k]), .stop_i(stop_act),
      .force_off_i(force_off), .mode66_i(mode66_i[k]), .clk_o(pci_o[k])
    );

    p_stop_parks_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (stop_act && !free_i[k] && !mode66_i[k]) |=> !pci_o[k]);
    p_en_off_r8: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!en_i[k] && !mode66_i[k]) |=> !pci_o[k]);
    p_free_keep_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (en_i[k] && free_i[k] && !mode66_i[k] && !force_off) |=> pci_o[k]);
    if (IS_SHARED) begin : g_shared
      p_shared_low_r9: assert property (@(negedge clk_i) disable iff (!rst_ni)
        strap_q |=> !pci_o[k]);
    end
  end

  pcs_gate_cell u_free (
    .clk_i(clk_i), .clk2x_i(clk2x_i), .rst_ni(rst_ni),
    .en_i(en_free_i), .hold_i(1'b1), .stop_i(stop_act),
    .force_off_i(1'b0), .mode66_i(1'b0), .clk_o(pci_free_o)
  );

  p_free_always_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    en_free_i |=> pci_free_o);
endmodule

// File: tb/pci_clk_stop_bench.sv
`timescale 1ns/100ps
module pci_clk_stop_bench;
  localparam int N = 6;
  localparam int SH = 5;

  logic clk_i = 0, clk2x_i = 0, rst_ni = 0;
  logic strap_stop_i = 1, stop_ni = 1, en_free_i = 1;
  logic [N-1:0] en_i = '1, free_i = '0, mode66_i = 6'b000011;
  logic [N-1:0] pci_o;
  logic pci_free_o;

  int vectors = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  pci_clk_stop #(.N_OUT(N), .SHARED_IDX(SH)) u_pci_clk_stop (
    .clk_i(clk_i), .clk2x_i(clk2x_i), .rst_ni(rst_ni), .strap_stop_i(strap_stop_i),
    .stop_ni(stop_ni), .en_i(en_i), .free_i(free_i), .mode66_i(mode66_i),
    .en_free_i(en_free_i), .pci_o(pci_o), .pci_free_o(pci_free_o)
  );

  // 200 MHz fast clock, base clock at half rate, rising edges aligned
  initial forever begin
    #2.5 clk2x_i = 1; clk_i = ~clk_i;
    #2.5 clk2x_i = 0;
  end

  // behavioural reference model
  int stop_hist[$];
  bit strap_m, strap_done_m;
  logic [N-1:0] run33_m, run66_m;
  logic free_m;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_hist = {1, 1};
      strap_m = 0; strap_done_m = 0;
    end else begin
      stop_hist.push_back(int'(stop_ni));
      if (stop_hist.size() > 4) void'(stop_hist.pop_front());
      if (!strap_done_m) begin strap_m = strap_stop_i; strap_done_m = 1; end
    end
  end

  always @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run33_m <= '0; free_m <= 0;
    end else begin
      bit stopping;
      stopping = strap_m && (stop_hist[stop_hist.size()-2] == 0);
      for (int k = 0; k < N; k++)
        run33_m[k] <= en_i[k] && !(k == SH && strap_m) && (free_i[k] || !stopping);
      free_m <= en_free_i;
    end
  end

  always @(negedge clk2x_i or negedge rst_ni) begin
    if (!rst_ni) run66_m <= '0;
    else for (int k = 0; k < N; k++) run66_m[k] <= en_i[k] && !(k == SH && strap_m);
  end

  always @(clk2x_i) begin
    #1.2;
    if (!done) begin
      for (int k = 0; k < N; k++) begin
        logic exp;
        exp = mode66_i[k] ? (clk2x_i & run66_m[k]) : (clk_i & run33_m[k]);
        vectors++;
        if (pci_o[k] !== exp) begin
          errors++;
          $display("FAIL %s out%0d at %0t: got %b exp %b",
                   mode66_i[k] ? "R6" : cur_req, k, $time, pci_o[k], exp);
        end
      end
      vectors++;
      if (pci_free_o !== (clk_i & free_m)) begin
        errors++;
        $display("FAIL R5 free at %0t: got %b exp %b", $time, pci_free_o, clk_i & free_m);
      end
    end
  end

  // R3: full-width high phases on a base-rate output
  realtime rise_t;
  always @(posedge pci_o[3]) rise_t = $realtime;
  always @(negedge pci_o[3]) if (rst_ni && !done) begin
    vectors++;
    if ($realtime - rise_t != 5.0) begin
      errors++;
      $display("FAIL R3 high width got %0f exp 5.0", $realtime - rise_t);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
    #0.5;
  endtask

  task automatic do_reset(input bit strap);
    cur_req = "R1";
    rst_ni = 0; strap_stop_i = strap; stop_ni = 1;
    step(3);
    rst_ni = 1;
    step(1);
    cur_req = "R9";
    step(6);
  endtask

  initial begin
    #0.5;
    do_reset(1);
    en_i = '1; free_i = '0;
    cur_req = "R2"; stop_ni = 0; step(10);
    cur_req = "R4"; stop_ni = 1; step(8);
    cur_req = "R7"; free_i = 6'b000100; stop_ni = 0; step(8);
    cur_req = "R4"; stop_ni = 1; free_i = '0; step(6);
    cur_req = "R3"; stop_ni = 0; step(1); stop_ni = 1; step(1); stop_ni = 0; step(3); stop_ni = 1; step(5);
    cur_req = "R8"; en_i = 6'b110111; step(5);
    en_i = 6'b111110; step(4); en_i = '1; step(4);
    cur_req = "R5"; en_free_i = 0; stop_ni = 0; step(5);
    en_free_i = 1; step(5); stop_ni = 1; step(4);
    mode66_i = 6'b000001;
    do_reset(0);
    cur_req = "R9"; stop_ni = 0; step(10); stop_ni = 1; step(4);
    cur_req = "R8"; en_i = 6'b011111; step(4); en_i = '1; step(4);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule